// File: doc/BRIEF.md
# Byte-Stream Frame Aligner and Framing Monitor

This block sits behind a deserializer that hands over one 8-bit byte per clock with no knowledge of where the transmitted bytes begin. It keeps a short history of received bytes and tests all eight bit offsets at once for the framing marker. The marker is one start byte followed by one closing byte, or, when `long_mode` is set, two start bytes followed by two closing bytes. When a marker is found while out of frame, the block locks that bit offset. It then realigns every later byte to it and pairs the realigned bytes into 16-bit words. A start-of-frame strobe marks the first word after each marker.

A four-state framing machine confirms the lock. It expects the marker to close again exactly one frame period after the previous one. It promotes a candidate lock to full sync, and it tolerates up to three consecutive bad markers before it flags a severely errored frame. It raises loss of frame once the link has stayed out of sync for a set number of frame periods. The frame length, the errored-frame threshold and the loss-of-frame persistence are parameters, so short frames can be used when exercising the block.

Top module: `frame_align_monitor`

## Requirements
- R1: After reset the state is out-of-frame (`frame_state` = 0), `out_of_frame` is 1, `in_frame`, `sev_err_frame`, `loss_of_frame`, `word_valid` and `word_sof` are 0.
- R2: With `long_mode` = 0 the marker is byte 0xF6 followed by byte 0x28, found at any of the eight bit offsets (MSB of each byte first on the line). Later bytes are realigned to that offset and paired into `word_out`, the earlier byte in bits 15:8, with `word_valid` high for one cycle per word.
- R3: `word_sof` is high together with `word_valid` on the word whose upper byte is the first byte after a marker. This recurs once per frame.
- R4: With `long_mode` = 1 the marker is 0xF6, 0xF6, 0x28, 0x28. A lone 0xF6 0x28 pair does not leave out-of-frame.
- R5: `frame_state` encodes OOF = 0, PRESYNC = 1, SYNC = 2, SEF = 3. A marker seen in OOF moves to PRESYNC. A marker closing exactly `FRAME_BYTES` bytes after the previous one moves PRESYNC to SYNC.
- R6: In PRESYNC, a missing marker at the expected position returns the state to OOF, and hunting over all offsets resumes.
- R7: In SYNC the bit offset and frame timing are frozen. A marker at any other position has no effect on state or word timing.
- R8: In SYNC, four consecutive frames with a wrong marker at the expected position move to SEF (`sev_err_frame` = 1, `in_frame` stays 1). Three do not.
- R9: In SEF, a correct marker at the expected position returns to SYNC.
- R10: `loss_of_frame` rises after `LOF_FRAMES` consecutive frame periods spent outside SYNC and clears once SYNC is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Unaligned byte from the deserializer |
| long_mode | input | 1 | 1 selects the four-byte marker |
| word_out | output | 16 | Realigned 16-bit word |
| word_valid | output | 1 | `word_out` carries a new word |
| word_sof | output | 1 | First word after a marker |
| in_frame | output | 1 | State is SYNC or SEF |
| out_of_frame | output | 1 | State is OOF |
| sev_err_frame | output | 1 | State is SEF |
| loss_of_frame | output | 1 | Persistent loss of frame |
| frame_state | output | 2 | Framing state code |

## Verification
The bench feeds marker streams at several bit slips in both marker modes and compares every realigned word and start strobe in order. An off-by-one in offset selection or word pairing would therefore corrupt the whole payload stream. It drops a marker during PRESYNC, which catches a machine that promotes without a second confirmation or never re-hunts. It plants a stray marker mid-frame in SYNC, which catches a design that re-locks on any match. It corrupts exactly three and then four markers to pin the SEF threshold, and it holds the link unframed to see loss of frame rise late enough and fall on resync.

// File: rtl/fam_pkg.sv
package fam_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int N_OFF      = BYTE_W;
    localparam int OFF_W      = $clog2(N_OFF);
    localparam int HIST_BYTES = 5;
    localparam int WIN_W      = HIST_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0] MARK_START = 8'hF6;
    localparam logic [BYTE_W-1:0] MARK_CLOSE = 8'h28;

    typedef enum logic [1:0] {
        FS_OOF     = 2'd0,
        FS_PRESYNC = 2'd1,
        FS_SYNC    = 2'd2,
        FS_SEF     = 2'd3
    } frame_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sof;
    } word_t;

    // Byte number idx (0 = oldest) of the window, taken at bit offset off.
    function automatic logic [BYTE_W-1:0] slice_byte(
        input logic [WIN_W-1:0] win,
        input logic [OFF_W-1:0] off,
        input logic [1:0]       idx
    );
        logic [WIN_W-1:0] sh;
        logic [5:0]       amt;
        amt = {3'b000, off} + {1'b0, idx, 3'b000};
        sh  = win << amt;
        return sh[WIN_W-1 -: BYTE_W];
    endfunction

endpackage

// File: rtl/fam_aligner.sv
module fam_aligner
    import fam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              long_mode,
    input  logic              hunt_en,
    output logic              found_any,
    output logic              locked_hit,
    output logic [BYTE_W-1:0] aligned_byte
);

    logic [HIST_BYTES-1:0][BYTE_W-1:0] hist;
    logic [WIN_W-1:0]                  win;
    logic [N_OFF-1:0]                  match;
    logic [OFF_W-1:0]                  found_off;
    logic [OFF_W-1:0]                  lock_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[HIST_BYTES-2:0], rx_byte};
        end
    end

    assign win = hist;

    for (genvar g = 0; g < N_OFF; g++) begin : g_off
        logic [BYTE_W-1:0] b0, b1, b2, b3;
        assign b0 = slice_byte(win, OFF_W'(g), 2'd0);
        assign b1 = slice_byte(win, OFF_W'(g), 2'd1);
        assign b2 = slice_byte(win, OFF_W'(g), 2'd2);
        assign b3 = slice_byte(win, OFF_W'(g), 2'd3);
        assign match[g] = long_mode
            ? (b0 == MARK_START && b1 == MARK_START && b2 == MARK_CLOSE && b3 == MARK_CLOSE)
            : (b2 == MARK_START && b3 == MARK_CLOSE);
    end

    always_comb begin
        found_off = '0;
        for (int i = N_OFF - 1; i >= 0; i--) begin
            if (match[i]) found_off = OFF_W'(i);
        end
    end

    assign found_any = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_off <= '0;
        end else if (hunt_en && found_any) begin
            lock_off <= found_off;
        end
    end

    assign locked_hit   = match[lock_off];
    assign aligned_byte = slice_byte(win, lock_off, 2'd3);

    // R7
    offset_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !hunt_en |=> $stable(lock_off));

endmodule

// File: rtl/fam_sync_fsm.sv
module fam_sync_fsm
    import fam_pkg::*;
#(
    parameter int FRAME_BYTES = 38880,
    parameter int ERR_FRAMES  = 4,
    parameter int LOF_FRAMES  = 24
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           found_any,
    input  logic                           locked_hit,
    output frame_state_e                   state,
    output logic [$clog2(FRAME_BYTES)-1:0] pos,
    output logic                           lof
);

    localparam int POS_W = $clog2(FRAME_BYTES);
    localparam int ERR_W = $clog2(ERR_FRAMES + 1);
    localparam int LOF_W = $clog2(LOF_FRAMES + 1);

    logic [ERR_W-1:0] errcnt;
    logic [LOF_W-1:0] lofcnt;
    logic             at_end;

    assign at_end = (pos == POS_W'(FRAME_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_OOF;
            pos    <= '0;
            errcnt <= '0;
        end else begin
            pos <= at_end ? '0 : pos + 1'b1;
            unique case (state)
                FS_OOF: begin
                    if (found_any) begin
                        state  <= FS_PRESYNC;
                        pos    <= '0;
                        errcnt <= '0;
                    end
                end
                FS_PRESYNC: begin
                    if (at_end) state <= locked_hit ? FS_SYNC : FS_OOF;
                end
                FS_SYNC: begin
                    if (at_end) begin
                        if (locked_hit) begin
                            errcnt <= '0;
                        end else if (errcnt == ERR_W'(ERR_FRAMES - 1)) begin
                            state  <= FS_SEF;
                            errcnt <= '0;
                        end else begin
                            errcnt <= errcnt + 1'b1;
                        end
                    end
                end
                FS_SEF: begin
                    if (at_end && locked_hit) begin
                        state  <= FS_SYNC;
                        errcnt <= '0;
                    end
                end
                default: state <= FS_OOF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lofcnt <= '0;
        end else if (state == FS_SYNC) begin
            lofcnt <= '0;
        end else if (at_end && lofcnt != LOF_W'(LOF_FRAMES)) begin
            lofcnt <= lofcnt + 1'b1;
        end
    end

    assign lof = (lofcnt == LOF_W'(LOF_FRAMES));

    // R5
    presync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FS_PRESYNC && $past(state) != FS_PRESYNC) |-> $past(state) == FS_OOF);

    // R5
    sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FS_SYNC && $past(state) == FS_PRESYNC) |-> $past(at_end && locked_hit));

    // R6
    presync_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FS_OOF && $past(state) == FS_PRESYNC) |-> $past(at_end && !locked_hit));

    // R8
    sef_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == FS_SEF && $past(state) != FS_SEF) |-> $past(state) == FS_SYNC);

    // R10
    lof_clear_chk: assert property (@(posedge clk) disable iff (rst)
        state == FS_SYNC |=> !lof);

endmodule

// File: rtl/fam_packer.sv
module fam_packer
    import fam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] aligned_byte,
    input  logic              odd_slot,
    input  logic              first_slot,
    input  logic              active,
    output word_t             word,
    output logic              word_valid
);

    logic [BYTE_W-1:0] hi_byte;
    logic              hi_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_byte    <= '0;
            hi_first   <= 1'b0;
            word       <= '0;
            word_valid <= 1'b0;
        end else if (!odd_slot) begin
            hi_byte    <= aligned_byte;
            hi_first   <= first_slot;
            word_valid <= 1'b0;
            word.sof   <= 1'b0;
        end else begin
            word.data  <= {hi_byte, aligned_byte};
            word.sof   <= hi_first && active;
            word_valid <= active;
        end
    end

    // R3
    sof_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        word.sof |-> word_valid);

endmodule

// File: rtl/frame_align_monitor.sv
module frame_align_monitor
    import fam_pkg::*;
#(
    parameter int FRAME_BYTES = 38880,
    parameter int ERR_FRAMES  = 4,
    parameter int LOF_FRAMES  = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_byte,
    input  logic        long_mode,
    output logic [15:0] word_out,
    output logic        word_valid,
    output logic        word_sof,
    output logic        in_frame,
    output logic        out_of_frame,
    output logic        sev_err_frame,
    output logic        loss_of_frame,
    output logic [1:0]  frame_state
);

    localparam int POS_W = $clog2(FRAME_BYTES);

    logic              found_any;
    logic              locked_hit;
    logic [BYTE_W-1:0] aligned_byte;
    frame_state_e      state;
    logic [POS_W-1:0]  pos;
    word_t             word;

    fam_aligner u_align (
        .clk          (clk),
        .rst          (rst),
        .rx_byte      (rx_byte),
        .long_mode    (long_mode),
        .hunt_en      (state == FS_OOF),
        .found_any    (found_any),
        .locked_hit   (locked_hit),
        .aligned_byte (aligned_byte)
    );

    fam_sync_fsm #(
        .FRAME_BYTES (FRAME_BYTES),
        .ERR_FRAMES  (ERR_FRAMES),
        .LOF_FRAMES  (LOF_FRAMES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .found_any  (found_any),
        .locked_hit (locked_hit),
        .state      (state),
        .pos        (pos),
        .lof        (loss_of_frame)
    );

    fam_packer u_pack (
        .clk          (clk),
        .rst          (rst),
        .aligned_byte (aligned_byte),
        .odd_slot     (pos[0]),
        .first_slot   (pos == '0),
        .active       (state != FS_OOF),
        .word         (word),
        .word_valid   (word_valid)
    );

    assign word_out      = word.data;
    assign word_sof      = word.sof;
    assign frame_state   = state;
    assign out_of_frame  = (state == FS_OOF);
    assign sev_err_frame = (state == FS_SEF);
    assign in_frame      = (state == FS_SYNC) || (state == FS_SEF);

    // R2
    word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R8
    sef_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sev_err_frame |-> in_frame);

endmodule

// File: tb/frame_align_monitor_bench.sv
`timescale 1ns/1ps
module frame_align_monitor_bench;

    localparam int FB   = 40;
    localparam int LOFN = 4;
    localparam int LEAD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        long_mode = 1'b0;
    logic [15:0] word_out;
    logic        word_valid, word_sof, in_frame, out_of_frame;
    logic        sev_err_frame, loss_of_frame;
    logic [1:0]  frame_state;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit sb_on  = 0;
    logic [7:0]  tx [0:1023];
    logic [16:0] expq [$];

    always #2.5 clk = ~clk;

    frame_align_monitor #(
        .FRAME_BYTES (FB),
        .ERR_FRAMES  (4),
        .LOF_FRAMES  (LOFN)
    ) u_frame_align_monitor (
        .clk           (clk),
        .rst           (rst),
        .rx_byte       (rx_byte),
        .long_mode     (long_mode),
        .word_out      (word_out),
        .word_valid    (word_valid),
        .word_sof      (word_sof),
        .in_frame      (in_frame),
        .out_of_frame  (out_of_frame),
        .sev_err_frame (sev_err_frame),
        .loss_of_frame (loss_of_frame),
        .frame_state   (frame_state)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each produced word with the queue head.
    always @(negedge clk) begin
        if (!rst && sb_on && word_valid && expq.size() > 0) begin
            logic [16:0] e;
            e = expq.pop_front();
            check_eq("R2", "word data", int'(word_out), int'(e[15:0]));
            check_eq("R3", "word sof", int'(word_sof), int'(e[16]));
        end
    end

    function automatic int fbase(int f);
        return LEAD + f * FB;
    endfunction

    task automatic build(int nfr, bit lng);
        for (int i = 0; i < 1024; i++) tx[i] = 8'h00;
        for (int f = 0; f < nfr; f++) begin
            for (int i = 0; i < FB; i++) begin
                tx[fbase(f) + i] = 8'((i * 5 + f * 3) & 8'h0F);
            end
            if (lng) begin
                tx[fbase(f)]     = 8'hF6;
                tx[fbase(f) + 1] = 8'hF6;
                tx[fbase(f) + 2] = 8'h28;
                tx[fbase(f) + 3] = 8'h28;
            end else begin
                tx[fbase(f)]     = 8'hF6;
                tx[fbase(f) + 1] = 8'h28;
            end
        end
    endtask

    // Driver side of the scoreboard: expected words from the built stream.
    task automatic push_expected(int mlen, int total);
        expq.delete();
        for (int j = LEAD + mlen; j + 1 < total; j += 2) begin
            expq.push_back({((j - LEAD - mlen) % FB) == 0, tx[j], tx[j + 1]});
        end
    endtask

    task automatic feed_range(int from, int to, int s);
        for (int n = from; n < to; n++) begin
            logic [15:0] t;
            t = {tx[n], tx[n + 1]};
            @(negedge clk);
            rx_byte = t[15 - s -: 8];
        end
    endtask

    task automatic do_reset(bit lng);
        sb_on = 0;
        @(negedge clk);
        rst = 1'b1;
        rx_byte = 8'h00;
        long_mode = lng;
        repeat (3) @(negedge clk);
        expq.delete();
        rst = 1'b0;
    endtask

    task automatic mid(int f, int s, ref int cur);
        feed_range(cur, fbase(f) + 20, s);
        cur = fbase(f) + 20;
    endtask

    initial begin
        int cur;
        // R1: reset state
        do_reset(1'b0);
        @(negedge clk);
        check_eq("R1", "frame_state", int'(frame_state), 0);
        check_eq("R1", "out_of_frame", int'(out_of_frame), 1);
        check_eq("R1", "in_frame", int'(in_frame), 0);
        check_eq("R1", "sev_err_frame", int'(sev_err_frame), 0);
        check_eq("R1", "loss_of_frame", int'(loss_of_frame), 0);
        check_eq("R1", "word_valid", int'(word_valid), 0);
        check_eq("R1", "word_sof", int'(word_sof), 0);

        // R2 R3 R5: short marker, slip of 3 bits
        do_reset(1'b0);
        build(6, 1'b0);
        push_expected(2, fbase(6));
        sb_on = 1;
        cur = 0;
        mid(0, 3, cur);
        check_eq("R5", "presync after first marker", int'(frame_state), 1);
        mid(1, 3, cur);
        check_eq("R5", "sync after second marker", int'(frame_state), 2);
        check_eq("R5", "in_frame in sync", int'(in_frame), 1);
        feed_range(cur, fbase(6) + 4, 3);
        check_eq("R2", "all words seen", expq.size(), 0);
        check_eq("R10", "no lof while synced", int'(loss_of_frame), 0);

        // R4 R2: long marker, slip of 6 bits
        do_reset(1'b1);
        build(5, 1'b1);
        push_expected(4, fbase(5));
        sb_on = 1;
        cur = 0;
        mid(1, 6, cur);
        check_eq("R4", "long marker reaches sync", int'(frame_state), 2);
        feed_range(cur, fbase(5) + 4, 6);
        check_eq("R4", "all long-mode words seen", expq.size(), 0);

        // R4: long mode ignores a short marker
        do_reset(1'b1);
        build(4, 1'b0);
        cur = 0;
        mid(3, 5, cur);
        check_eq("R4", "short marker ignored in long mode", int'(out_of_frame), 1);

        // R6: missing second marker drops back, then re-hunt
        do_reset(1'b0);
        build(6, 1'b0);
        tx[fbase(1)] = 8'h00;
        tx[fbase(1) + 1] = 8'h00;
        cur = 0;
        mid(0, 2, cur);
        check_eq("R6", "presync before drop", int'(frame_state), 1);
        mid(1, 2, cur);
        check_eq("R6", "oof after missing marker", int'(frame_state), 0);
        mid(2, 2, cur);
        check_eq("R6", "re-hunt finds marker", int'(frame_state), 1);
        mid(3, 2, cur);
        check_eq("R6", "sync after re-hunt", int'(frame_state), 2);

        // R7 R8 R9: stray marker, then errored markers
        do_reset(1'b0);
        build(10, 1'b0);
        tx[fbase(2) + 10] = 8'hF6;
        tx[fbase(2) + 11] = 8'h28;
        for (int f = 3; f <= 6; f++) tx[fbase(f) + 1] = 8'h05;
        push_expected(2, fbase(10));
        sb_on = 1;
        cur = 0;
        mid(2, 1, cur);
        check_eq("R7", "stray marker ignored", int'(frame_state), 2);
        mid(5, 1, cur);
        check_eq("R8", "three errors keep sync", int'(frame_state), 2);
        check_eq("R8", "no sef after three", int'(sev_err_frame), 0);
        mid(6, 1, cur);
        check_eq("R8", "four errors give sef", int'(frame_state), 3);
        check_eq("R8", "sef flag", int'(sev_err_frame), 1);
        check_eq("R8", "in_frame held in sef", int'(in_frame), 1);
        mid(7, 1, cur);
        check_eq("R9", "good marker back to sync", int'(frame_state), 2);
        check_eq("R9", "sef flag cleared", int'(sev_err_frame), 0);
        feed_range(cur, fbase(10) + 4, 1);
        check_eq("R7", "word timing kept", expq.size(), 0);

        // R10: loss of frame persistence and clear
        do_reset(1'b0);
        build(9, 1'b0);
        for (int f = 0; f < 6; f++) begin
            tx[fbase(f)] = 8'h00;
            tx[fbase(f) + 1] = 8'h00;
        end
        cur = 0;
        mid(2, 4, cur);
        check_eq("R10", "no lof too early", int'(loss_of_frame), 0);
        mid(5, 4, cur);
        check_eq("R10", "lof after persistence", int'(loss_of_frame), 1);
        mid(6, 4, cur);
        check_eq("R10", "lof held in presync", int'(loss_of_frame), 1);
        mid(7, 4, cur);
        check_eq("R10", "lof cleared in sync", int'(loss_of_frame), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule